// File: doc/BRIEF.md
# Three-Phase Gate Driver Fault Supervisor

This block is the protection manager for a six-output, three-phase gate driver. It takes digitised and synchronised flags for logic-supply undervoltage, the three high-side supply undervoltages and an over-current comparator. It also takes the six active-low phase commands. From these it produces a global drive enable, a per-phase high-side enable and an active-low fault indication. The analog comparators, their hysteresis and the open-drain pad sit outside the block.

An over-current trip is accepted only after it has been present for a programmable blanking count. The accepted trip then passes through a programmable shutdown delay before it sets a fault latch. That latch holds until all three low-side commands are inactive together. A logic-supply undervoltage forces shutdown and the fault indication only while it lasts. A high-side supply undervoltage removes only that phase's high-side enable. When that supply recovers, the phase stays off until its high-side command shows a new falling edge. All outputs are registered.

Top module: `gdrv_fault_sup`

## Requirements
- R1: When an over-current trip is accepted, `drive_en`, `fault_n` and every `hs_en` bit go low. This happens at the edge `DLY_CYC` clocks after the accepting sample.
- R2: A trip is accepted only on its `BLANK_CYC+1`-th consecutive high sample. A trip that is high for `BLANK_CYC` or fewer consecutive samples has no effect on any output.
- R3: After the trip input falls, the over-current fault stays latched. It clears at the first edge that samples `lo_cmd_n` equal to all ones (every low-side command inactive), and the outputs return at that same edge.
- R4: If the latch is set and cleared at the same edge, the set wins. A trip that is held, with `lo_cmd_n` all ones, keeps the fault asserted.
- R5: While `vlog_uv` is sampled high, `drive_en`, `fault_n` and `hs_en` are low one edge later. The condition is not latched: outputs return one edge after `vlog_uv` is sampled low. No output turns on while `vlog_uv` is high.
- R6: `vhs_uv[i]` high clears `hs_en[i]` one edge later. It leaves the other phases, `drive_en` and `fault_n` unchanged.
- R7: Phase i is armed at an edge where `hi_cmd_n[i]` is sampled 0, `hi_cmd_n[i]` was sampled 1 at the previous edge, and `vhs_uv[i]` is low. `hs_en[i]` rises at that edge. A phase that is not armed stays off. A rising command edge, or a constant level, does not arm it.
- R8: Under reset (synchronous, active high) all outputs are 0, the over-current latch is set and every phase is disarmed. Leaving reset therefore requires a low-side clear and fresh high-side falling edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| vlog_uv | input | 1 | Logic supply below threshold |
| vhs_uv | input | NPH | Per-phase high-side supply below threshold |
| oc_trip | input | 1 | Over-current comparator output |
| hi_cmd_n | input | NPH | Active-low high-side phase commands |
| lo_cmd_n | input | NPH | Active-low low-side phase commands |
| drive_en | output | 1 | Global enable for all six gate outputs |
| hs_en | output | NPH | Per-phase high-side enable |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The properties assume that every input is already synchronous to `clk` and that it holds for whole cycles. They also assume the inputs hold defined values from the first edge of reset. The edge-based re-arm and release checks look two samples back, so they rely on this. The stimulus drives every input on the falling clock edge from a single table or task, one cycle per step. It never leaves an input undriven. Through the bench parameters it keeps the blanking and delay counts small enough that a full trip, hold and release sequence fits in a few dozen steps.

// File: rtl/gfs_pkg.sv
package gfs_pkg;
  localparam int PHASES = 3;

  // True when every active-low command in the vector is inactive (high).
  function automatic logic all_idle(input logic [PHASES-1:0] cmd_n);
    return &cmd_n;
  endfunction
endpackage

// File: rtl/gfs_trip_qual.sv
module gfs_trip_qual #(
  parameter int BLANK_CYC = 100,
  parameter int DLY_CYC   = 65
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_trip,
  output logic trip_set
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(BLANK_CYC);

  logic [CW-1:0] run_cnt;
  logic          hit;

  // Count consecutive high samples, saturating at the blanking count.
  always_ff @(posedge clk) begin
    if (rst)                 run_cnt <= '0;
    else if (!oc_trip)       run_cnt <= '0;
    else if (run_cnt != CNT_MAX) run_cnt <= run_cnt + 1'b1;
  end

  assign hit = oc_trip && (run_cnt == CNT_MAX);

  generate
    if (DLY_CYC == 0) begin : g_nodly
      assign trip_set = hit;
    end else begin : g_dly
      logic [DLY_CYC-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) begin
          pipe <= '0;
        end else begin
          pipe[0] <= hit;
          for (int s = 1; s < DLY_CYC; s++) pipe[s] <= pipe[s-1];
        end
      end
      assign trip_set = pipe[DLY_CYC-1];
    end
  endgenerate
endmodule

// File: rtl/gfs_hs_arm.sv
module gfs_hs_arm (
  input  logic clk,
  input  logic rst,
  input  logic hs_uv,
  input  logic cmd_n,
  output logic armed_nxt
);
  logic prev_n;
  logic armed;

  always_comb begin
    if (hs_uv)                  armed_nxt = 1'b0;
    else if (prev_n && !cmd_n)  armed_nxt = 1'b1;
    else                        armed_nxt = armed;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_n <= 1'b0;
      armed  <= 1'b0;
    end else begin
      prev_n <= cmd_n;
      armed  <= armed_nxt;
    end
  end
endmodule

// File: rtl/gdrv_fault_sup.sv
module gdrv_fault_sup #(
  parameter int NPH       = gfs_pkg::PHASES,
  parameter int BLANK_CYC = 100,
  parameter int DLY_CYC   = 65
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           vlog_uv,
  input  logic [NPH-1:0] vhs_uv,
  input  logic           oc_trip,
  input  logic [NPH-1:0] hi_cmd_n,
  input  logic [NPH-1:0] lo_cmd_n,
  output logic           drive_en,
  output logic [NPH-1:0] hs_en,
  output logic           fault_n
);
  logic           trip_set;
  logic           oc_lat;
  logic           oc_nxt;
  logic           ok_nxt;
  logic [NPH-1:0] armed_nxt;

  gfs_trip_qual #(.BLANK_CYC(BLANK_CYC), .DLY_CYC(DLY_CYC)) u_trip (
    .clk      (clk),
    .rst      (rst),
    .oc_trip  (oc_trip),
    .trip_set (trip_set)
  );

  generate
    for (genvar p = 0; p < NPH; p++) begin : g_ph
      gfs_hs_arm u_arm (
        .clk       (clk),
        .rst       (rst),
        .hs_uv     (vhs_uv[p]),
        .cmd_n     (hi_cmd_n[p]),
        .armed_nxt (armed_nxt[p])
      );
    end
  endgenerate

  // Set has priority over the low-side clear.
  always_comb begin
    if (trip_set)       oc_nxt = 1'b1;
    else if (&lo_cmd_n) oc_nxt = 1'b0;
    else                oc_nxt = oc_lat;
    ok_nxt = !oc_nxt && !vlog_uv;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oc_lat   <= 1'b1;
      drive_en <= 1'b0;
      fault_n  <= 1'b0;
      hs_en    <= '0;
    end else begin
      oc_lat   <= oc_nxt;
      drive_en <= ok_nxt;
      fault_n  <= ok_nxt;
      hs_en    <= armed_nxt & {NPH{ok_nxt}};
    end
  end
endmodule

// File: rtl/gfs_checker.sv
module gfs_checker #(
  parameter int NPH = 3
) (
  input logic           clk,
  input logic           rst,
  input logic           vlog_uv,
  input logic [NPH-1:0] vhs_uv,
  input logic [NPH-1:0] hi_cmd_n,
  input logic [NPH-1:0] lo_cmd_n,
  input logic           drive_en,
  input logic [NPH-1:0] hs_en,
  input logic           fault_n,
  input logic           trip_set
);
  p_trip_shut_r1: assert property (@(posedge clk) disable iff (rst)
    trip_set |=> (!drive_en && !fault_n && (hs_en == '0)));

  p_trip_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (trip_set && (&lo_cmd_n)) |=> !fault_n);

  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n) |-> ($past(&lo_cmd_n) || $past(vlog_uv, 2)));

  p_uv_shut_r5: assert property (@(posedge clk) disable iff (rst)
    vlog_uv |=> (!drive_en && !fault_n));

  p_uv_gate_r5: assert property (@(posedge clk) disable iff (rst)
    drive_en |-> !$past(vlog_uv));

  generate
    for (genvar g = 0; g < NPH; g++) begin : g_ph
      p_hs_uv_r6: assert property (@(posedge clk) disable iff (rst)
        vhs_uv[g] |=> !hs_en[g]);

      p_rearm_r7: assert property (@(posedge clk) disable iff (rst)
        ($rose(hs_en[g]) && $past(drive_en)) |-> !$past(hi_cmd_n[g]));
    end
  endgenerate
endmodule

bind gdrv_fault_sup gfs_checker #(.NPH(NPH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .vlog_uv  (vlog_uv),
  .vhs_uv   (vhs_uv),
  .hi_cmd_n (hi_cmd_n),
  .lo_cmd_n (lo_cmd_n),
  .drive_en (drive_en),
  .hs_en    (hs_en),
  .fault_n  (fault_n),
  .trip_set (trip_set)
);

// File: tb/tb_gdrv_fault_sup.sv
module tb_gdrv_fault_sup;
  localparam int NPH = 3;
  localparam int NV  = 37;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           vlog_uv = 1'b1;
  logic [NPH-1:0] vhs_uv = '1;
  logic           oc_trip = 1'b0;
  logic [NPH-1:0] hi_cmd_n = '1;
  logic [NPH-1:0] lo_cmd_n = '0;
  logic           drive_en;
  logic [NPH-1:0] hs_en;
  logic           fault_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  gdrv_fault_sup #(.NPH(NPH), .BLANK_CYC(4), .DLY_CYC(2)) dut (
    .clk(clk), .rst(rst), .vlog_uv(vlog_uv), .vhs_uv(vhs_uv),
    .oc_trip(oc_trip), .hi_cmd_n(hi_cmd_n), .lo_cmd_n(lo_cmd_n),
    .drive_en(drive_en), .hs_en(hs_en), .fault_n(fault_n)
  );

  // Row: req[19:16] uv[15] hsuv[14:12] trip[11] hi[10:8] lo[7:5] | drv[4] fn[3] hs[2:0]
  localparam logic [19:0] TBL [NV] = '{
    {4'd8,1'b0,3'b000,1'b0,3'b111,3'b000,1'b0,1'b0,3'b000}, // R8 latch held from reset
    {4'd3,1'b0,3'b000,1'b0,3'b111,3'b111,1'b1,1'b1,3'b000}, // R3 clear
    {4'd7,1'b0,3'b000,1'b0,3'b110,3'b111,1'b1,1'b1,3'b001}, // R7
    {4'd7,1'b0,3'b000,1'b0,3'b100,3'b111,1'b1,1'b1,3'b011}, // R7
    {4'd7,1'b0,3'b000,1'b0,3'b000,3'b111,1'b1,1'b1,3'b111}, // R7
    {4'd6,1'b0,3'b010,1'b0,3'b000,3'b111,1'b1,1'b1,3'b101}, // R6
    {4'd7,1'b0,3'b000,1'b0,3'b000,3'b111,1'b1,1'b1,3'b101}, // R7 level only
    {4'd7,1'b0,3'b000,1'b0,3'b010,3'b111,1'b1,1'b1,3'b101}, // R7 rising edge
    {4'd7,1'b0,3'b000,1'b0,3'b000,3'b111,1'b1,1'b1,3'b111}, // R7 falling edge
    {4'd5,1'b1,3'b000,1'b0,3'b000,3'b111,1'b0,1'b0,3'b000}, // R5
    {4'd5,1'b0,3'b000,1'b0,3'b000,3'b111,1'b1,1'b1,3'b111}, // R5 not latched
    {4'd2,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111}, // R2
    {4'd2,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd2,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd2,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd2,1'b0,3'b000,1'b0,3'b000,3'b111,1'b1,1'b1,3'b111}, // R2 short trip ignored
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111}, // R1
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111}, // accepting sample
    {4'd1,1'b0,3'b000,1'b0,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd4,1'b0,3'b000,1'b0,3'b000,3'b111,1'b0,1'b0,3'b000}, // R4 set beats clear
    {4'd3,1'b0,3'b000,1'b0,3'b000,3'b011,1'b0,1'b0,3'b000}, // R3 hold
    {4'd3,1'b0,3'b000,1'b0,3'b000,3'b101,1'b0,1'b0,3'b000}, // R3 hold
    {4'd3,1'b0,3'b000,1'b0,3'b000,3'b111,1'b1,1'b1,3'b111}, // R3 release
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b1,1'b1,3'b111},
    {4'd1,1'b0,3'b000,1'b1,3'b000,3'b111,1'b0,1'b0,3'b000}, // R1 shutdown
    {4'd4,1'b0,3'b000,1'b1,3'b000,3'b111,1'b0,1'b0,3'b000}, // R4 held trip
    {4'd4,1'b0,3'b000,1'b0,3'b000,3'b111,1'b0,1'b0,3'b000},
    {4'd4,1'b0,3'b000,1'b0,3'b000,3'b111,1'b0,1'b0,3'b000},
    {4'd3,1'b0,3'b000,1'b0,3'b000,3'b111,1'b1,1'b1,3'b111}  // R3 release
  };

  task automatic check(input int req, input logic [4:0] exp_v);
    logic [4:0] act;
    act = {drive_en, fault_n, hs_en};
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL R%0d: drv/fault_n/hs actual %b expected %b", req, act, exp_v);
    end
  endtask

  task automatic step(input logic r, input logic uv, input logic [2:0] hsuv,
                      input logic trip, input logic [2:0] hi, input logic [2:0] lo);
    rst = r; vlog_uv = uv; vhs_uv = hsuv; oc_trip = trip; hi_cmd_n = hi; lo_cmd_n = lo;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    repeat (3) step(1'b1, 1'b1, 3'b111, 1'b0, 3'b111, 3'b000);
    check(8, 5'b00000); // R8 reset state

    for (int i = 0; i < NV; i++) begin
      step(1'b0, TBL[i][15], TBL[i][14:12], TBL[i][11], TBL[i][10:8], TBL[i][7:5]);
      check(int'(TBL[i][19:16]), TBL[i][4:0]);
    end

    // R8: reset mid-operation clears outputs even with good inputs
    step(1'b1, 1'b0, 3'b000, 1'b0, 3'b000, 3'b111);
    check(8, 5'b00000);
    // R5: no output while logic supply is low, even with the clear condition
    step(1'b0, 1'b1, 3'b000, 1'b0, 3'b000, 3'b111);
    check(5, 5'b00000);
    // R8: after reset the phases stay disarmed until fresh falling edges
    step(1'b0, 1'b0, 3'b000, 1'b0, 3'b000, 3'b111);
    check(8, 5'b11000);
    step(1'b0, 1'b0, 3'b000, 1'b0, 3'b111, 3'b111);
    check(7, 5'b11000);
    step(1'b0, 1'b0, 3'b000, 1'b0, 3'b011, 3'b111);
    check(7, 5'b11100);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule